// File: doc/BRIEF.md
# Flow-Through Burst Static Memory

A synchronous single-port memory of parameterised depth. Each word is 36 bits wide, split into four lanes of nine bits, with eight data bits and one parity bit per lane. An access starts on one of two start strobes. The host start strobe always opens a read. The controller start strobe reads or writes, depending on the write inputs. While no strobe is active, the access either steps through a four-word burst or stays on its current word. The burst order is wrapping linear or interleaved, chosen by a static select input.

Reads are flow-through. The word at the address captured at a rising edge appears on the data output during the cycle that follows, with no extra register stage. The output is gated by an output-enable input. Three chip-select inputs decide whether a start opens an access or closes the current one. A sleep input freezes the block and turns the output off.

The data pins are split into an input bus, an output bus and an output-enable flag, so the pad ring can build the shared bidirectional pin.

Top module: `fts_sram`

## Requirements
- R1: After reset, `dqOutEn` is 0 and `dqOut` is all zeros until an access is opened.
- R2: The block counts as selected only when `enANeg`=0, `enBPos`=1 and `enCNeg`=0. A start taken with any other combination closes the access. The output is then off from the next edge until a new access opens, and that cycle writes nothing.
- R3: While `enANeg`=1 the host start strobe is ignored, so the current access carries on. A controller start while `enANeg`=1 closes the access.
- R4: When `allWriteN`=0, a write cycle stores all four lanes, whatever `laneWriteN` and `laneSelN` hold.
- R5: With `allWriteN`=1 and `laneWriteN`=0, the cycle writes lane i exactly when `laneSelN[i]`=0. Lane i is bits [9i+8:9i], and bit 9i+8 is its parity bit. If `laneWriteN`=1, or if every `laneSelN` bit is 1, the cycle is a read.
- R6: The cycle opened by the host start strobe is a read, and the write inputs have no effect in it.
- R7: The word at the address captured at a rising edge appears on `dqOut` before the following edge.
- R8: With `interleaveSel`=0, each step cycle (`stepN`=0, no start) replaces the two low address bits with start+n mod 4 and wraps after four words. The upper bits stay the same.
- R9: With `interleaveSel`=1, the n-th burst word has low bits start XOR n.
- R10: A cycle with no start and `stepN`=1 keeps the current address.
- R11: `dqOutEn` is 1 only while `outEnN`=0 during an open read cycle. Write cycles, and cycles after the access is closed, keep it at 0.
- R12: While `sleepReq`=1 the output is off, no lane is written, and the address and burst position hold. After sleep ends, the output stays off until the next edge that opens or continues a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, captured on a start |
| enANeg | input | 1 | Chip select, active low; also qualifies the host start |
| enBPos | input | 1 | Chip select, active high |
| enCNeg | input | 1 | Chip select, active low |
| hostStartN | input | 1 | Host start strobe, active low, always opens a read |
| ctlStartN | input | 1 | Controller start strobe, active low, may write |
| stepN | input | 1 | Burst step, active low; high keeps the address |
| allWriteN | input | 1 | Write all lanes, active low |
| laneWriteN | input | 1 | Lane write enable, active low |
| laneSelN | input | LANES | Per-lane write selects, active low |
| outEnN | input | 1 | Output enable, active low, applied without a register |
| sleepReq | input | 1 | Sleep request, active high |
| interleaveSel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| dqIn | input | LANES*LANE_W | Write data, sampled at the write edge |
| dqOut | output | LANES*LANE_W | Read data, zero while not driven |
| dqOutEn | output | 1 | Pad driver enable for `dqOut` |

## Verification
A burst position that drifts shows up as a wrong word on `dqOut` in the very next read cycle, because each read leaves the array without a register stage. A wrong lane mask stays hidden until the word is read back. The bench therefore reads every mixed-mask word again after writing it. A stale read or access flag shows up at once as `dqOutEn` rising or falling one edge off. Deselects, ignored strobes and sleep are each followed by a read, so a write that should have been blocked would be caught.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int LANES = 4;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_SLEEP,
    CYC_HOST,
    CYC_CTRL,
    CYC_DESEL,
    CYC_CONT
  } cycKind_t;

  typedef struct packed {
    logic             loadAddr;
    logic             advance;
    logic [LANES-1:0] laneWe;
    logic             driveRead;
  } ctlStrobes_t;
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enANeg,
  input  logic             enBPos,
  input  logic             enCNeg,
  input  logic             hostStartN,
  input  logic             ctlStartN,
  input  logic             stepN,
  input  logic             allWriteN,
  input  logic             laneWriteN,
  input  logic [LANES-1:0] laneSelN,
  input  logic             sleepReq,
  output ctlStrobes_t      strb
);
  logic             activeQ, readQ;
  logic             activeD, readD;
  logic             selected;
  logic [LANES-1:0] reqMask;
  cycKind_t         kind;

  // Lane request decoded from the write inputs; global write wins.
  always_comb begin
    if (!allWriteN)       reqMask = '1;
    else if (!laneWriteN) reqMask = ~laneSelN;
    else                  reqMask = '0;
  end

  assign selected = !enANeg && enBPos && !enCNeg;

  // Classify the cycle; the host strobe only counts when enANeg is low.
  always_comb begin
    if (sleepReq)                     kind = CYC_SLEEP;
    else if (!hostStartN && !enANeg)  kind = selected ? CYC_HOST : CYC_DESEL;
    else if (!ctlStartN)              kind = selected ? CYC_CTRL : CYC_DESEL;
    else if (activeQ)                 kind = CYC_CONT;
    else                              kind = CYC_IDLE;
  end

  always_comb begin
    strb    = '0;
    activeD = activeQ;
    readD   = readQ;
    unique case (kind)
      CYC_SLEEP: readD = 1'b0;
      CYC_HOST: begin
        strb.loadAddr = 1'b1;
        activeD       = 1'b1;
        readD         = 1'b1;
      end
      CYC_CTRL: begin
        strb.loadAddr = 1'b1;
        strb.laneWe   = reqMask;
        activeD       = 1'b1;
        readD         = (reqMask == '0);
      end
      CYC_DESEL: begin
        activeD = 1'b0;
        readD   = 1'b0;
      end
      CYC_CONT: begin
        strb.advance = !stepN;
        strb.laneWe  = reqMask;
        readD        = (reqMask == '0);
      end
      default: readD = readQ;
    endcase
    strb.driveRead = readQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      readQ   <= 1'b0;
    end else begin
      activeQ <= activeD;
      readQ   <= readD;
    end
  end
endmodule

// File: rtl/fts_burst.sv
module fts_burst #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadAddr,
  input  logic          advance,
  input  logic          interleave,
  input  logic [AW-1:0] addrIn,
  output logic [AW-1:0] curAddr,
  output logic [AW-1:0] cycAddr
);
  localparam int HI_W = AW - 2;

  logic [HI_W-1:0] hiQ;
  logic [1:0]      baseQ;
  logic [1:0]      cntQ;
  logic [1:0]      cntNext;

  function automatic logic [1:0] seqLow(input logic [1:0] b, input logic [1:0] n,
                                        input logic il);
    return il ? (b ^ n) : (b + n);
  endfunction

  assign cntNext = cntQ + 2'd1;
  assign curAddr = {hiQ, seqLow(baseQ, cntQ, interleave)};

  // Address used by the current edge: fresh, stepped or held.
  always_comb begin
    if (loadAddr)     cycAddr = addrIn;
    else if (advance) cycAddr = {hiQ, seqLow(baseQ, cntNext, interleave)};
    else              cycAddr = curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ   <= '0;
      baseQ <= '0;
      cntQ  <= '0;
    end else if (loadAddr) begin
      hiQ   <= addrIn[AW-1:2];
      baseQ <= addrIn[1:0];
      cntQ  <= '0;
    end else if (advance) begin
      cntQ  <= cntNext;
    end
  end
endmodule

// File: rtl/fts_datapath.sv
module fts_datapath
  import fts_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        laneWe,
  input  logic [AW-1:0]           cycAddr,
  input  logic [AW-1:0]           curAddr,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    driveRead,
  input  logic                    outEnN,
  input  logic                    sleepReq,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);
  localparam int DEPTH  = 1 << AW;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] rdWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (laneWe[g]) laneMem[cycAddr] <= dIn[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = laneMem[curAddr];
  end

  assign dOutEn = driveRead && !outEnN && !sleepReq;
  assign dOut   = dOutEn ? rdWord : '0;
endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    enANeg,
  input  logic                    enBPos,
  input  logic                    enCNeg,
  input  logic                    hostStartN,
  input  logic                    ctlStartN,
  input  logic                    stepN,
  input  logic                    allWriteN,
  input  logic                    laneWriteN,
  input  logic [LANES-1:0]        laneSelN,
  input  logic                    outEnN,
  input  logic                    sleepReq,
  input  logic                    interleaveSel,
  input  logic [LANES*LANE_W-1:0] dqIn,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqOutEn
);
  ctlStrobes_t       strb;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] cycAddr;

  fts_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enANeg(enANeg), .enBPos(enBPos), .enCNeg(enCNeg),
    .hostStartN(hostStartN), .ctlStartN(ctlStartN), .stepN(stepN),
    .allWriteN(allWriteN), .laneWriteN(laneWriteN), .laneSelN(laneSelN),
    .sleepReq(sleepReq), .strb(strb)
  );

  fts_burst #(.AW(ADDR_W)) burst_i (
    .clk(clk), .rstN(rstN), .loadAddr(strb.loadAddr), .advance(strb.advance),
    .interleave(interleaveSel), .addrIn(addr), .curAddr(curAddr), .cycAddr(cycAddr)
  );

  fts_datapath #(.AW(ADDR_W), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .laneWe(strb.laneWe), .cycAddr(cycAddr), .curAddr(curAddr),
    .dIn(dqIn), .driveRead(strb.driveRead), .outEnN(outEnN), .sleepReq(sleepReq),
    .dOut(dqOut), .dOutEn(dqOutEn)
  );
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk
  import fts_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          enANeg,
  input logic          enBPos,
  input logic          enCNeg,
  input logic          hostStartN,
  input logic          ctlStartN,
  input logic          outEnN,
  input logic          sleepReq,
  input logic          interleaveSel,
  input logic          dqOutEn,
  input ctlStrobes_t   strb,
  input logic [AW-1:0] curAddr
);
  // R11
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOutEn |-> (!outEnN && !sleepReq));

  // R12
  sleep_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |-> (strb.laneWe == '0));

  // R12
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> $stable(curAddr));

  // R2
  desel_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepReq && !hostStartN && !enANeg && (!enBPos || enCNeg)) |=> !strb.driveRead);

  // R3
  ctl_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepReq && enANeg && !ctlStartN) |=> !strb.driveRead);

  // R6
  host_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepReq && !hostStartN && !enANeg) |-> (strb.laneWe == '0));

  // R8
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !interleaveSel) |=>
      (interleaveSel || curAddr[1:0] == $past(curAddr[1:0]) + 2'd1));

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (curAddr[AW-1:2] == $past(curAddr[AW-1:2])));
endmodule

bind fts_sram fts_sram_chk #(.AW(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .enANeg(enANeg), .enBPos(enBPos), .enCNeg(enCNeg),
  .hostStartN(hostStartN), .ctlStartN(ctlStartN), .outEnN(outEnN),
  .sleepReq(sleepReq), .interleaveSel(interleaveSel), .dqOutEn(dqOutEn),
  .strb(strb), .curAddr(curAddr)
);

// File: tb/fts_sram_tb_top.sv
module fts_sram_tb_top;
  localparam logic [2:0] SEL = 3'b010; // {enANeg, enBPos, enCNeg}

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  addr = '0;
  logic        enANeg = 1'b1, enBPos = 1'b0, enCNeg = 1'b1;
  logic        hostStartN = 1'b1, ctlStartN = 1'b1, stepN = 1'b1;
  logic        allWriteN = 1'b1, laneWriteN = 1'b1;
  logic [3:0]  laneSelN = 4'hF;
  logic        outEnN = 1'b1, sleepReq = 1'b0, interleaveSel = 1'b0;
  logic [35:0] dqIn = '0;
  logic [35:0] dqOut;
  logic        dqOutEn;

  always #4 clk = ~clk;

  fts_sram dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .enANeg(enANeg), .enBPos(enBPos),
    .enCNeg(enCNeg), .hostStartN(hostStartN), .ctlStartN(ctlStartN), .stepN(stepN),
    .allWriteN(allWriteN), .laneWriteN(laneWriteN), .laneSelN(laneSelN),
    .outEnN(outEnN), .sleepReq(sleepReq), .interleaveSel(interleaveSel),
    .dqIn(dqIn), .dqOut(dqOut), .dqOutEn(dqOutEn)
  );

  typedef struct {
    logic        en;
    logic [35:0] data;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          compared = 0;
  int          mismatched = 0;
  bit          done = 1'b0;

  // Shadow model state
  logic [35:0] shadow [64];
  bit          mActive = 0, mRead = 0;
  logic [3:0]  mHi = '0;
  logic [1:0]  mBase = '0, mCnt = '0;

  function automatic logic [35:0] pat(input int i);
    return (36'(i) * 36'h0_1F3D_5B79) ^ 36'h3_0C00_0011;
  endfunction

  // Driver: apply one cycle, update the shadow, queue the expected output.
  task automatic step(input logic [5:0] a, input logic [2:0] ce, input logic pN,
                      input logic cN, input logic vN, input logic gN, input logic beN,
                      input logic [3:0] bN, input logic oN, input logic slp,
                      input logic md, input logic [35:0] d, input string tag);
    exp_t       it;
    logic       sel;
    logic [3:0] mask;
    logic [5:0] curA;
    @(negedge clk);
    addr = a; {enANeg, enBPos, enCNeg} = ce; hostStartN = pN; ctlStartN = cN;
    stepN = vN; allWriteN = gN; laneWriteN = beN; laneSelN = bN; outEnN = oN;
    sleepReq = slp; interleaveSel = md; dqIn = d;
    sel  = !ce[2] && ce[1] && !ce[0];
    mask = !gN ? 4'hF : (!beN ? ~bN : 4'h0);
    if (slp) begin
      mRead = 0; mask = 4'h0;
    end else if (!pN && !ce[2]) begin
      mask = 4'h0;
      if (sel) begin mHi = a[5:2]; mBase = a[1:0]; mCnt = 0; mActive = 1; mRead = 1; end
      else begin mActive = 0; mRead = 0; end
    end else if (!cN) begin
      if (sel) begin mHi = a[5:2]; mBase = a[1:0]; mCnt = 0; mActive = 1; mRead = (mask == 0); end
      else begin mActive = 0; mRead = 0; mask = 4'h0; end
    end else if (mActive) begin
      if (!vN) mCnt = mCnt + 2'd1;
      mRead = (mask == 0);
    end else begin
      mask = 4'h0;
    end
    curA = {mHi, md ? (mBase ^ mCnt) : (mBase + mCnt)};
    for (int l = 0; l < 4; l++)
      if (mask[l]) shadow[curA][l*9 +: 9] = d[l*9 +: 9];
    it.en   = mRead && !oN && !slp;
    it.data = it.en ? shadow[curA] : 36'h0;
    it.tag  = tag;
    q.push_back(it);
  endtask

  // Convenience wrappers
  task automatic hostRead(input logic [5:0] a, input logic md, input string tag);
    step(a, SEL, 0, 1, 1, 1, 1, 4'hF, 0, 0, md, 36'h0, tag);
  endtask
  task automatic cont(input logic vN, input logic beN, input logic [3:0] bN,
                      input logic [35:0] d, input logic md, input string tag);
    step(6'd0, SEL, 1, 1, vN, 1, beN, bN, 0, 0, md, d, tag);
  endtask

  // Monitor: compare each cycle's output against the queued expectation.
  always @(posedge clk) begin
    exp_t it;
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      compared++;
      if (dqOutEn !== it.en || dqOut !== it.data) begin
        mismatched++;
        $display("FAIL %s: actual en=%0b data=%h expected en=%0b data=%h",
                 it.tag, dqOutEn, dqOut, it.en, it.data);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: idle after reset, nothing driven
    step(6'd0, 3'b101, 1, 1, 1, 1, 1, 4'hF, 0, 0, 0, 36'h0, "R1");
    // R4: fill every word with the global write (laneWriteN held high, selects high)
    for (int i = 0; i < 64; i++)
      step(6'(i), SEL, 1, 0, 1, 0, 1, 4'hF, 0, 0, 0, pat(i), "R4");
    // R6: host start with global write low still reads, R7 word appears at once
    step(6'd5, SEL, 0, 1, 1, 0, 0, 4'h0, 0, 0, 0, 36'hF_FFFF_FFFF, "R6");
    // R8: linear burst from 5 -> 6, 7, 4, 5
    for (int k = 0; k < 4; k++) cont(0, 1, 4'hF, 36'h0, 0, "R8");
    // R9: interleaved burst from 5 -> 5, 4, 7, 6
    hostRead(6'd5, 1, "R9");
    for (int k = 0; k < 3; k++) cont(0, 1, 4'hF, 36'h0, 1, "R9");
    // R10: suspend holds word 6
    cont(1, 1, 4'hF, 36'h0, 1, "R10");
    cont(1, 1, 4'hF, 36'h0, 1, "R10");
    // R5: mixed lane masks in a linear burst from 9
    step(6'd9, SEL, 1, 0, 1, 1, 0, 4'b1010, 0, 0, 0, 36'hA_5A5A_5A5A, "R5");
    cont(0, 0, 4'b0101, 36'h1_2345_6789, 0, "R5");
    cont(0, 0, 4'b0111, 36'hF_0F0F_0F0F, 0, "R5");
    cont(0, 0, 4'hF, 36'h0, 0, "R5");          // all selects high: read word 8
    cont(0, 1, 4'h0, 36'h0, 0, "R5");          // lane write off: read word 9
    hostRead(6'd10, 0, "R5");
    hostRead(6'd11, 0, "R5");
    // R11: output enable high blocks driving, then low drives
    step(6'd12, SEL, 0, 1, 1, 1, 1, 4'hF, 1, 0, 0, 36'h0, "R11");
    cont(1, 1, 4'hF, 36'h0, 0, "R11");
    // R2: selects wrong on controller start (write attempt) and host start
    step(6'd3, 3'b000, 1, 0, 1, 0, 1, 4'hF, 0, 0, 0, 36'h0, "R2");
    cont(0, 1, 4'hF, 36'h0, 0, "R2");
    step(6'd3, 3'b011, 0, 1, 1, 1, 1, 4'hF, 0, 0, 0, 36'h0, "R2");
    hostRead(6'd3, 0, "R2");
    // R3: host start ignored with enANeg high, controller start deselects
    hostRead(6'd20, 0, "R3");
    step(6'd40, 3'b110, 0, 1, 1, 1, 1, 4'hF, 0, 0, 0, 36'h0, "R3");
    step(6'd40, 3'b110, 0, 0, 1, 1, 1, 4'hF, 0, 0, 0, 36'h0, "R3");
    cont(1, 1, 4'hF, 36'h0, 0, "R3");
    // R7: controller-start read drives in the following cycle
    step(6'd40, SEL, 1, 0, 1, 1, 1, 4'hF, 0, 0, 0, 36'h0, "R7");
    // R12: sleep blocks writes and holds address, then the access carries on
    hostRead(6'd30, 0, "R12");
    step(6'd31, SEL, 1, 0, 0, 0, 0, 4'h0, 0, 1, 0, 36'h0, "R12");
    step(6'd31, SEL, 1, 1, 0, 0, 0, 4'h0, 0, 1, 0, 36'h0, "R12");
    cont(1, 1, 4'hF, 36'h0, 0, "R12");
    hostRead(6'd31, 0, "R12");
    // R1/R11 again: idle, deselected
    step(6'd0, 3'b101, 1, 0, 1, 1, 1, 4'hF, 0, 0, 0, 36'h0, "R11");
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule